// File: doc/BRIEF.md
# Privileged Indirect Register Access Router

This block sits between a hart's indirect register access port and a set of interrupt files. Each request names a privilege level, a virtualization flag, a 6-bit guest index, an access width (32 or 64 bits) and a 9-bit register select. The router picks one interrupt-file page, or rejects the request. On an accepted request it reads the addressed register and applies a masked read-modify-write. The response carries the value held before the write and an error flag.

Each page holds a delivery-enable bit, a priority threshold, and one pending bit and one enable bit per interrupt identity. It can be built in two ways. A machine-level build has a single page. A supervisor-level build has page 0 for the supervisor plus guest pages 1 and up. The page state is brought out on ports so that a companion core can arbitrate it. That companion also supplies, for each page, the identity of the current top interrupt. The message-doorbell path and the priority search are not part of this block.

Requests use a valid/ready handshake, and ready is always high. The response is registered and appears one cycle after the request is accepted.

Top module: `ireg_router`

## Requirements
- R1: With MMODE=1, a request is accepted only when the privilege is machine (code 3) and the virtualization flag is clear, and it maps to page 0. Every other privilege/flag combination sets the error flag.
- R2: With MMODE=0, a supervisor request (privilege code 1) with the virtualization flag clear maps to page 0. User (code 0), reserved (code 2) and machine privilege set the error flag.
- R3: With MMODE=0, a supervisor request with the virtualization flag set maps to the page named by the guest index. The index must be nonzero and below NUM_PAGES, otherwise the error flag is set.
- R4: An accepted request stores (old & ~mask) | (data & mask) into the addressed register and returns the old value. A zero mask makes the request a pure read.
- R5: The delivery-enable register (select 0x070) holds only bit 0. The threshold register (select 0x072) holds only its low ID_W bits.
- R6: Pending words use selects 0x080+n and enable words use 0x0C0+n, for n = 0..63. In 32-bit mode, word n holds identities 32n to 32n+31, with bit i standing for identity 32n+i.
- R7: In 64-bit mode an odd n sets the error flag, and an even n addresses the 64 identities starting at 32n. In 32-bit mode, data bits 63:32 of the response are zero.
- R8: A word whose halved (64-bit mode) or plain (32-bit mode) index is at or above NUM_SRC divided by the access width sets the error flag.
- R9: Identity 0 is never pending and never enabled. Writes to bit 0 of word 0 are ignored.
- R10: A select that matches no register, or any rejected request, sets the error flag, returns data 0 and changes no page state.
- R11: The top-interrupt register (select 0x100) reads as (T << 16) | T, where T is the page's top_id input. A request with a nonzero mask and T nonzero clears pending bit T.
- R12: req_ready is always 1. rsp_valid is high exactly in the cycle after each accepted request, and rsp_data and rsp_err are valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken (always 1) |
| req_priv | input | 2 | Privilege: 0 user, 1 supervisor, 3 machine |
| req_virt | input | 1 | Virtualized access |
| req_gidx | input | 6 | Guest index for virtualized accesses |
| req_x64 | input | 1 | 1 = 64-bit access width, 0 = 32-bit |
| req_sel | input | 9 | Register select number |
| req_wdata | input | 64 | Write data |
| req_wmask | input | 64 | Write mask, 1 = bit is written |
| top_id | input | NUM_PAGES*ID_W | Top interrupt identity per page from the companion core |
| rsp_valid | output | 1 | Response present |
| rsp_data | output | 64 | Old register value, 0 on error |
| rsp_err | output | 1 | Request rejected |
| deliv_o | output | NUM_PAGES | Delivery-enable bit per page |
| thresh_o | output | NUM_PAGES*ID_W | Threshold per page |
| pend_o | output | NUM_PAGES*NUM_SRC | Pending bits, page-major |
| enab_o | output | NUM_PAGES*NUM_SRC | Enable bits, page-major |

## Verification
The assertions check the following on every cycle:
- the one-cycle response timing and the always-high ready;
- zero data on errors and the zero upper half in 32-bit mode;
- rejection of illegal privilege or guest combinations;
- that identity 0 stays clear;
- that pages which no request addressed keep their state;
- that a top-interrupt write really drops its bit.

The bench's reference model compares every response and all page state on each clock. That comparison is what shows the read-modify-write values, the lane mapping of 32- and 64-bit words, the threshold width and the top-interrupt encoding. It also shows that rejected requests leave every register untouched.

// File: rtl/ireg_pkg.sv
// Package: shared encodings for the indirect register router.
// Assumes a 9-bit select space and 64-bit data lanes.
package ireg_pkg;
    localparam int SEL_W   = 9;
    localparam int GIDX_W  = 6;
    localparam int DATA_W  = 64;
    localparam int WIDX_W  = 6;
    localparam int BIT_W   = 12;
    localparam int TOP_SHIFT = 16;

    localparam logic [1:0] PRIV_U = 2'd0;
    localparam logic [1:0] PRIV_S = 2'd1;
    localparam logic [1:0] PRIV_M = 2'd3;

    localparam logic [SEL_W-1:0] SEL_DELIV  = 9'h070;
    localparam logic [SEL_W-1:0] SEL_THRESH = 9'h072;
    localparam logic [SEL_W-1:0] SEL_TOP    = 9'h100;
    localparam logic [SEL_W-WIDX_W-1:0] PEND_HI = 3'b010;
    localparam logic [SEL_W-WIDX_W-1:0] ENAB_HI = 3'b011;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_DELIV,
        RK_THRESH,
        RK_TOP,
        RK_PEND,
        RK_ENAB
    } reg_kind_e;
endpackage

// File: rtl/ireg_decode.sv
// Module: ireg_decode
// Purely combinational. Turns a request's privilege, virtualization flag,
// guest index, access width and select into a page number, a register
// kind and a bit offset into the page's identity vectors. ok is low for
// any rejected request. Assumes NUM_SRC is a multiple of 64.
module ireg_decode
    import ireg_pkg::*;
#(
    parameter bit MMODE     = 1'b0,
    parameter int NUM_PAGES = 4,
    parameter int NUM_SRC   = 64,
    parameter int PG_W      = 2
) (
    input  logic [1:0]        priv,
    input  logic              virt,
    input  logic [GIDX_W-1:0] gidx,
    input  logic              x64,
    input  logic [SEL_W-1:0]  sel,
    output logic              ok,
    output logic [PG_W-1:0]   page,
    output reg_kind_e         kind,
    output logic [BIT_W-1:0]  bit_base
);
    localparam int WORDS32 = NUM_SRC / 32;
    localparam int WORDS64 = NUM_SRC / 64;

    logic              page_ok;
    logic              word_ok;
    logic [WIDX_W-1:0] widx;
    logic [WIDX_W-1:0] weff;

    // Page selection from privilege, virtualization and guest index.
    always_comb begin
        page_ok = 1'b0;
        page    = '0;
        if (MMODE) begin
            page_ok = (priv == PRIV_M) && !virt;
        end else if (priv == PRIV_S) begin
            if (!virt) begin
                page_ok = 1'b1;
            end else if ((gidx != '0) && (32'(gidx) < NUM_PAGES)) begin
                page_ok = 1'b1;
                page    = PG_W'(gidx);
            end
        end
    end

    // Register kind from the select number.
    always_comb begin
        kind = RK_NONE;
        if (sel == SEL_DELIV)
            kind = RK_DELIV;
        else if (sel == SEL_THRESH)
            kind = RK_THRESH;
        else if (sel == SEL_TOP)
            kind = RK_TOP;
        else if (sel[SEL_W-1:WIDX_W] == PEND_HI)
            kind = RK_PEND;
        else if (sel[SEL_W-1:WIDX_W] == ENAB_HI)
            kind = RK_ENAB;
    end

    assign widx = sel[WIDX_W-1:0];

    // Word index legality and bit offset for the chosen access width.
    always_comb begin
        weff     = x64 ? (widx >> 1) : widx;
        word_ok  = x64 ? (!widx[0] && (32'(weff) < WORDS64))
                       : (32'(weff) < WORDS32);
        bit_base = x64 ? (BIT_W'(weff) << 6) : (BIT_W'(weff) << 5);
    end

    // Overall acceptance.
    assign ok = page_ok && (kind != RK_NONE) &&
                (((kind != RK_PEND) && (kind != RK_ENAB)) || word_ok);

    // An accepted word access never starts beyond the identity vector.
    always_comb begin
        if (ok && ((kind == RK_PEND) || (kind == RK_ENAB)))
            AST_BASE_IN_RANGE: assert (32'(bit_base) < NUM_SRC); // R8
    end
endmodule

// File: rtl/ireg_page.sv
// Module: ireg_page
// State of one interrupt file: delivery enable, threshold, pending and
// enable vectors. It presents the old value of the addressed register
// and applies the masked update when wr_en is high. Assumes the decoder
// has already checked kind, page and word range. top_id comes from the
// companion core and is 0 when nothing is pending.
module ireg_page
    import ireg_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int ID_W    = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  reg_kind_e          kind,
    input  logic [BIT_W-1:0]   bit_base,
    input  logic               x64,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [DATA_W-1:0]  wmask,
    input  logic [ID_W-1:0]    top_id,
    output logic [DATA_W-1:0]  rdata,
    output logic               deliv_o,
    output logic [ID_W-1:0]    thresh_o,
    output logic [NUM_SRC-1:0] pend_o,
    output logic [NUM_SRC-1:0] enab_o
);
    logic               deliv_q;
    logic [ID_W-1:0]    thr_q;
    logic [NUM_SRC-1:0] pend_q;
    logic [NUM_SRC-1:0] enab_q;

    logic [DATA_W-1:0]  lane_mask;
    logic [DATA_W-1:0]  word_old;
    logic [NUM_SRC-1:0] vec_sel;
    logic [NUM_SRC-1:0] spread_m;
    logic [NUM_SRC-1:0] spread_d;
    logic [NUM_SRC-1:0] vec_new;
    logic [NUM_SRC-1:0] top_clr;
    logic               top_hit;

    // Lanes that the access width makes usable.
    assign lane_mask = x64 ? '1 : 64'h0000_0000_FFFF_FFFF;

    // Extract the addressed word and merge the masked write into the vector.
    always_comb begin
        vec_sel  = (kind == RK_ENAB) ? enab_q : pend_q;
        word_old = DATA_W'(vec_sel >> bit_base) & lane_mask;
        spread_m = (NUM_SRC'(wmask & lane_mask) << bit_base) & ~NUM_SRC'(1);
        spread_d = NUM_SRC'(wdata) << bit_base;
        vec_new  = (vec_sel & ~spread_m) | (spread_d & spread_m);
    end

    // Pending bit that a top-interrupt write would retire.
    assign top_hit = (top_id != '0) && (32'(top_id) < NUM_SRC) && (wmask != '0);
    assign top_clr = top_hit ? (NUM_SRC'(1) << top_id) : '0;

    // Old value of the addressed register.
    always_comb begin
        case (kind)
            RK_DELIV:        rdata = DATA_W'(deliv_q);
            RK_THRESH:       rdata = DATA_W'(thr_q);
            RK_TOP:          rdata = (DATA_W'(top_id) << TOP_SHIFT) | DATA_W'(top_id);
            RK_PEND, RK_ENAB: rdata = word_old;
            default:         rdata = '0;
        endcase
    end

    // Register update on an accepted request for this page.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            deliv_q <= 1'b0;
            thr_q   <= '0;
            pend_q  <= '0;
            enab_q  <= '0;
        end else if (wr_en) begin
            case (kind)
                RK_DELIV:  deliv_q <= (deliv_q & ~wmask[0]) | (wdata[0] & wmask[0]);
                RK_THRESH: thr_q   <= (thr_q & ~wmask[ID_W-1:0]) |
                                      (wdata[ID_W-1:0] & wmask[ID_W-1:0]);
                RK_TOP:    pend_q  <= pend_q & ~top_clr;
                RK_PEND:   pend_q  <= vec_new;
                RK_ENAB:   enab_q  <= vec_new;
                default:   ;
            endcase
        end
    end

    assign deliv_o  = deliv_q;
    assign thresh_o = thr_q;
    assign pend_o   = pend_q;
    assign enab_o   = enab_q;

    AST_ID0_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_q[0] && !enab_q[0]); // R9

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(pend_q) && $stable(enab_q) &&
                   $stable(thr_q) && $stable(deliv_q)); // R10

    AST_TOP_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (kind == RK_TOP) && top_hit |=> (pend_q & $past(top_clr)) == '0); // R11
endmodule

// File: rtl/ireg_router.sv
// Module: ireg_router (top)
// Routes indirect register requests to one of NUM_PAGES interrupt files
// and returns the pre-write value one cycle later. MMODE=1 builds the
// machine-level variant with a single page. MMODE=0 builds the supervisor
// variant, where pages 1 and up serve guests. Assumes NUM_SRC is a
// multiple of 64 and NUM_PAGES is at most 64.
module ireg_router
    import ireg_pkg::*;
#(
    parameter bit MMODE     = 1'b0,
    parameter int NUM_PAGES = 4,
    parameter int NUM_SRC   = 64,
    parameter int ID_W      = 11
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           req_valid,
    output logic                           req_ready,
    input  logic [1:0]                     req_priv,
    input  logic                           req_virt,
    input  logic [5:0]                     req_gidx,
    input  logic                           req_x64,
    input  logic [8:0]                     req_sel,
    input  logic [63:0]                    req_wdata,
    input  logic [63:0]                    req_wmask,
    input  logic [NUM_PAGES*ID_W-1:0]      top_id,
    output logic                           rsp_valid,
    output logic [63:0]                    rsp_data,
    output logic                           rsp_err,
    output logic [NUM_PAGES-1:0]           deliv_o,
    output logic [NUM_PAGES*ID_W-1:0]      thresh_o,
    output logic [NUM_PAGES*NUM_SRC-1:0]   pend_o,
    output logic [NUM_PAGES*NUM_SRC-1:0]   enab_o
);
    localparam int PG_W = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1;

    logic              dec_ok;
    logic [PG_W-1:0]   dec_page;
    reg_kind_e         dec_kind;
    logic [BIT_W-1:0]  dec_base;
    logic [DATA_W-1:0] pg_rdata [NUM_PAGES];
    logic [DATA_W-1:0] rd_sel;
    logic              acc;

    assign req_ready = 1'b1;
    assign acc       = req_valid && req_ready;

    ireg_decode #(
        .MMODE(MMODE), .NUM_PAGES(NUM_PAGES), .NUM_SRC(NUM_SRC), .PG_W(PG_W)
    ) u_dec (
        .priv(req_priv), .virt(req_virt), .gidx(req_gidx), .x64(req_x64),
        .sel(req_sel), .ok(dec_ok), .page(dec_page), .kind(dec_kind),
        .bit_base(dec_base)
    );

    // One interrupt file per page.
    for (genvar p = 0; p < NUM_PAGES; p++) begin : g_page
        ireg_page #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_page (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (acc && dec_ok && (dec_page == PG_W'(p))),
            .kind     (dec_kind),
            .bit_base (dec_base),
            .x64      (req_x64),
            .wdata    (req_wdata),
            .wmask    (req_wmask),
            .top_id   (top_id[p*ID_W +: ID_W]),
            .rdata    (pg_rdata[p]),
            .deliv_o  (deliv_o[p]),
            .thresh_o (thresh_o[p*ID_W +: ID_W]),
            .pend_o   (pend_o[p*NUM_SRC +: NUM_SRC]),
            .enab_o   (enab_o[p*NUM_SRC +: NUM_SRC])
        );
    end

    // Select the addressed page's old value.
    always_comb begin
        rd_sel = '0;
        for (int p = 0; p < NUM_PAGES; p++)
            if (dec_page == PG_W'(p)) rd_sel = pg_rdata[p];
    end

    // Registered response, one cycle after acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
            rsp_err   <= 1'b0;
        end else begin
            rsp_valid <= acc;
            rsp_err   <= acc && !dec_ok;
            rsp_data  <= (acc && dec_ok) ? rd_sel : '0;
        end
    end

    AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R12

    AST_RSP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R12

    AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_err |-> rsp_data == '0); // R10

    AST_MCFG_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        MMODE && req_valid && ((req_priv != PRIV_M) || req_virt) |=> rsp_err); // R1

    AST_GUEST_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !MMODE && req_valid && (req_priv == PRIV_S) && req_virt &&
        ((req_gidx == '0) || (32'(req_gidx) >= NUM_PAGES)) |=> rsp_err); // R3

    AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_x64 |=> rsp_data[63:32] == '0); // R7
endmodule

// File: tb/sim_ireg_router.sv
// Bench: behavioural reference model, compared on every falling clock edge.
module sim_ireg_router;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic        req_valid = 1'b0;
    logic [1:0]  req_priv = '0;
    logic        req_virt = 1'b0;
    logic [5:0]  req_gidx = '0;
    logic        req_x64 = 1'b0;
    logic [8:0]  req_sel = '0;
    logic [63:0] req_wdata = '0;
    logic [63:0] req_wmask = '0;
    logic [10:0] top_in [4];
    logic [43:0] top_flat;

    logic        rdy0, rdy1, rv0, rv1, re0, re1;
    logic [63:0] rd0, rd1;
    logic [3:0]  del0;
    logic [0:0]  del1;
    logic [43:0] thr0;
    logic [10:0] thr1;
    logic [255:0] pend0, enab0;
    logic [63:0] pend1, enab1;

    always_comb
        for (int p = 0; p < 4; p++) top_flat[p*11 +: 11] = top_in[p];

    ireg_router u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy0),
        .req_priv(req_priv), .req_virt(req_virt), .req_gidx(req_gidx),
        .req_x64(req_x64), .req_sel(req_sel), .req_wdata(req_wdata),
        .req_wmask(req_wmask), .top_id(top_flat), .rsp_valid(rv0),
        .rsp_data(rd0), .rsp_err(re0), .deliv_o(del0), .thresh_o(thr0),
        .pend_o(pend0), .enab_o(enab0)
    );

    ireg_router #(.MMODE(1'b1), .NUM_PAGES(1)) u1 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy1),
        .req_priv(req_priv), .req_virt(req_virt), .req_gidx(req_gidx),
        .req_x64(req_x64), .req_sel(req_sel), .req_wdata(req_wdata),
        .req_wmask(req_wmask), .top_id(top_in[0]), .rsp_valid(rv1),
        .rsp_data(rd1), .rsp_err(re1), .deliv_o(del1), .thresh_o(thr1),
        .pend_o(pend1), .enab_o(enab1)
    );

    // Reference state.
    bit [63:0]   mpend [4];
    bit [63:0]   menab [4];
    bit          mdel  [4];
    logic [10:0] mthr  [4];
    bit          m1del;

    logic        exp_vld = 1'b0;
    logic [63:0] exp_data;
    logic        exp_err, exp1_err;
    string       cur_tag = "R12";
    int          total = 0;
    int          bad = 0;
    bit          running = 1'b0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    // Model one request: compute the expected response and update the state.
    task automatic model(input bit [1:0] pv, input bit vt, input bit [5:0] gi,
                         input bit x, input bit [8:0] s,
                         input logic [63:0] d, input logic [63:0] m);
        int pg = 0;
        bit perr = 1'b0;
        bit kerr = 1'b0;
        int kind = 0;
        int n = 0;
        int xl = x ? 64 : 32;
        logic [63:0] old = '0;
        if (pv == 2'd1) begin
            if (vt) begin
                if (gi != 0 && gi < 4) pg = int'(gi);
                else perr = 1'b1;
            end
        end else perr = 1'b1;
        if (s == 9'h070) kind = 1;
        else if (s == 9'h072) kind = 2;
        else if (s == 9'h100) kind = 3;
        else if (s >= 9'h080 && s <= 9'h0BF) begin kind = 4; n = int'(s) - 128; end
        else if (s >= 9'h0C0 && s <= 9'h0FF) begin kind = 5; n = int'(s) - 192; end
        else kerr = 1'b1;
        if (kind >= 4) begin
            if (x) begin
                if (n % 2 != 0) kerr = 1'b1;
                n = n / 2;
            end
            if (n >= 64 / xl) kerr = 1'b1;
        end
        exp1_err = !(pv == 2'd3 && !vt) || kerr;
        if (!exp1_err && kind == 1) m1del = (m1del & !m[0]) | (d[0] & m[0]);
        exp_err = perr || kerr;
        if (!exp_err) begin
            case (kind)
                1: begin
                    old = 64'(mdel[pg]);
                    mdel[pg] = (mdel[pg] & !m[0]) | (d[0] & m[0]);
                end
                2: begin
                    old = 64'(mthr[pg]);
                    mthr[pg] = (mthr[pg] & ~m[10:0]) | (d[10:0] & m[10:0]);
                end
                3: begin
                    old = (64'(top_in[pg]) << 16) | 64'(top_in[pg]);
                    if (top_in[pg] != 0 && top_in[pg] < 64 && m != 0)
                        mpend[pg][top_in[pg]] = 1'b0;
                end
                default: begin
                    for (int i = 0; i < xl; i++) begin
                        int idx = n * xl + i;
                        old[i] = (kind == 4) ? mpend[pg][idx] : menab[pg][idx];
                        if (m[i] && idx != 0) begin
                            if (kind == 4) mpend[pg][idx] = d[i];
                            else menab[pg][idx] = d[i];
                        end
                    end
                end
            endcase
        end
        exp_data = exp_err ? 64'd0 : old;
    endtask

    // Issue one request, accepted at the next rising edge.
    task automatic req(input string tag, input bit [1:0] pv, input bit vt,
                       input bit [5:0] gi, input bit x, input bit [8:0] s,
                       input logic [63:0] d, input logic [63:0] m);
        @(negedge clk);
        req_valid = 1'b1; req_priv = pv; req_virt = vt; req_gidx = gi;
        req_x64 = x; req_sel = s; req_wdata = d; req_wmask = m;
        @(posedge clk);
        model(pv, vt, gi, x, s, d, m);
        cur_tag = tag;
        exp_vld = 1'b1;
        #1 req_valid = 1'b0;
    endtask

    // Cycle comparison against the model.
    always @(negedge clk) begin
        if (running) begin
            bit st_ok = 1'b1;
            chk(rv0 === exp_vld, cur_tag, "rsp_valid", 64'(rv0), 64'(exp_vld));
            chk(rv1 === exp_vld, "R12", "u1 rsp_valid", 64'(rv1), 64'(exp_vld));
            if (exp_vld) begin
                chk(re0 === exp_err, cur_tag, "rsp_err", 64'(re0), 64'(exp_err));
                chk(rd0 === exp_data, cur_tag, "rsp_data", rd0, exp_data);
                chk(re1 === exp1_err, cur_tag, "u1 rsp_err", 64'(re1), 64'(exp1_err));
            end
            for (int p = 0; p < 4; p++) begin
                if (pend0[p*64 +: 64] !== mpend[p] || enab0[p*64 +: 64] !== menab[p] ||
                    del0[p] !== mdel[p] || thr0[p*11 +: 11] !== mthr[p]) begin
                    st_ok = 1'b0;
                    chk(1'b0, cur_tag, "page state", pend0[p*64 +: 64], mpend[p]);
                end
            end
            if (st_ok) chk(1'b1, cur_tag, "page state", 0, 0);
            chk(del1[0] === m1del, cur_tag, "u1 deliv", 64'(del1), 64'(m1del));
            exp_vld = 1'b0;
        end
    end

    initial begin
        repeat (60000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int p = 0; p < 4; p++) begin
            top_in[p] = '0; mpend[p] = '0; menab[p] = '0; mdel[p] = 1'b0; mthr[p] = '0;
        end
        m1del = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        running = 1'b1;
        // R12: reset state and ready
        chk(rdy0 === 1'b1 && rdy1 === 1'b1, "R12", "ready", 64'(rdy0), 1);
        chk(rv0 === 1'b0 && pend0 === '0 && thr0 === '0, "R12", "reset state", 64'(rv0), 0);

        // R2: supervisor page 0, user/reserved/machine rejected
        req("R2", 2'd1, 0, 0, 0, 9'h070, 64'd1, 64'd1);
        req("R2", 2'd1, 0, 0, 0, 9'h070, 64'd0, 64'd0);
        req("R2", 2'd0, 0, 0, 0, 9'h070, 64'd0, 64'd1);
        req("R2", 2'd2, 0, 0, 0, 9'h072, 64'd5, '1);
        // R1: machine-level build
        req("R1", 2'd3, 0, 0, 0, 9'h070, 64'd1, 64'd1);
        req("R1", 2'd3, 1, 0, 0, 9'h070, 64'd0, 64'd1);
        req("R1", 2'd1, 0, 0, 0, 9'h070, 64'd0, 64'd1);
        req("R1", 2'd3, 0, 0, 0, 9'h070, 64'd0, 64'd0);
        // R3: guest pages
        req("R3", 2'd1, 1, 6'd1, 0, 9'h070, 64'd1, 64'd1);
        req("R3", 2'd1, 1, 6'd3, 0, 9'h072, 64'd7, '1);
        req("R3", 2'd1, 1, 6'd0, 0, 9'h070, 64'd1, 64'd1);
        req("R3", 2'd1, 1, 6'd4, 0, 9'h070, 64'd1, 64'd1);
        req("R3", 2'd1, 1, 6'd63, 0, 9'h072, 64'd1, '1);
        req("R3", 2'd1, 1, 6'd3, 0, 9'h072, 64'd0, 64'd0);
        // R5: field widths
        req("R5", 2'd1, 0, 0, 0, 9'h072, '1, '1);
        req("R5", 2'd1, 0, 0, 0, 9'h072, 64'd0, 64'd0);
        req("R5", 2'd1, 0, 0, 0, 9'h070, 64'hFFFE, '1);
        // R4: partial mask
        req("R4", 2'd1, 0, 0, 0, 9'h072, 64'd0, 64'h0F0);
        req("R4", 2'd1, 0, 0, 0, 9'h072, 64'h123, 64'h00F);
        req("R4", 2'd1, 0, 0, 0, 9'h072, 64'd0, 64'd0);
        // R6 / R9: 32-bit words
        req("R9", 2'd1, 0, 0, 0, 9'h080, '1, '1);
        req("R6", 2'd1, 0, 0, 0, 9'h080, 64'd0, 64'd0);
        req("R6", 2'd1, 0, 0, 0, 9'h081, 64'h8000_0001, 64'hFFFF_FFFF);
        req("R9", 2'd1, 0, 0, 1, 9'h0C0, 64'hF0F0_1234_5678_9ABD, '1);
        req("R6", 2'd1, 1, 6'd2, 0, 9'h0C1, 64'hA5A5_A5A5, 64'hFFFF_0000);
        // R7: 64-bit words
        req("R7", 2'd1, 0, 0, 1, 9'h080, 64'd0, 64'd0);
        req("R7", 2'd1, 0, 0, 1, 9'h081, '1, '1);
        req("R7", 2'd1, 0, 0, 0, 9'h081, 64'd0, 64'd0);
        req("R7", 2'd1, 0, 0, 1, 9'h0C0, 64'h0, 64'hFF00_0000_0000_0000);
        // R8: out-of-range words
        req("R8", 2'd1, 0, 0, 1, 9'h082, '1, '1);
        req("R8", 2'd1, 0, 0, 0, 9'h082, '1, '1);
        req("R8", 2'd1, 0, 0, 0, 9'h0FF, '1, '1);
        // R10: unmapped selects
        req("R10", 2'd1, 0, 0, 0, 9'h071, '1, '1);
        req("R10", 2'd1, 0, 0, 0, 9'h000, '1, '1);
        req("R10", 2'd1, 0, 0, 0, 9'h101, '1, '1);
        req("R10", 2'd1, 0, 0, 1, 9'h1FF, '1, '1);
        // R11: top-interrupt register
        @(negedge clk); top_in[0] = 11'd5; top_in[2] = 11'd40;
        req("R11", 2'd1, 0, 0, 0, 9'h100, 64'd0, 64'd0);
        req("R11", 2'd1, 0, 0, 0, 9'h100, 64'd0, 64'd1);
        req("R11", 2'd1, 1, 6'd2, 0, 9'h080, '1, '1);
        req("R11", 2'd1, 1, 6'd2, 0, 9'h081, '1, '1);
        req("R11", 2'd1, 1, 6'd2, 1, 9'h100, 64'd0, 64'h10);
        @(negedge clk); top_in[0] = 11'd0;
        req("R11", 2'd1, 0, 0, 0, 9'h100, '1, '1);

        // R4 / R12: randomized back-to-back mix
        for (int k = 0; k < 400; k++) begin
            bit [1:0] pv;
            bit [8:0] s;
            logic [63:0] m;
            int r = int'($urandom % 10);
            pv = (r < 6) ? 2'd1 : ((r < 8) ? 2'd3 : 2'(r));
            case ($urandom % 7)
                0: s = 9'h070;
                1: s = 9'h072;
                2: s = 9'h100;
                3: s = 9'h080 + 9'($urandom % 4);
                4: s = 9'h0C0 + 9'($urandom % 4);
                default: s = 9'($urandom);
            endcase
            m = ($urandom % 3 == 0) ? '1 : {$urandom, $urandom};
            if (k % 16 == 0) begin
                @(negedge clk);
                for (int p = 0; p < 4; p++) top_in[p] = 11'($urandom % 70);
            end
            req("R4", pv, 1'($urandom), 6'($urandom % 6), 1'($urandom), s,
                {$urandom, $urandom}, m);
        end
        repeat (3) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule